// File: doc/BRIEF.md
# Sixteen-Bit Reload Interval Timer

This block is an up-counting interval timer with a single mode. On every tick it adds one to its count. When a tick arrives at the all-ones count, it loads the count from a reload register and sets a sticky overflow flag. Software sets the overflow interval by writing the reload register one byte at a time. To make the first interval start right away, software presets the count to all ones.

A control register chooses where ticks come from. One source is an asynchronous external oscillator input. That input is synchronized, and one tick is made for every eighth rising edge. The other two sources are every system clock cycle, or one cycle in twelve. Selecting the external source overrides the system-clock choice.

Each overflow also gives a one-cycle strobe, which can start a data converter. An interrupt request is raised while the flag is set and the interrupt enable input is high.

Top module: `reload_timer16`

## Requirements
- R1: After reset the count, the reload value and the control read value are all 0x0000/0x00, and `irq` and `conv_start` are low.
- R2: Count and reload are written by byte. Select bit 0 writes bits 7:0 and select bit 1 writes bits 15:8. A count write takes effect at the clock edge on which it is presented and takes precedence over a tick on that edge.
- R3: While the run bit (control bit 2) is 0, the count does not change except by a count write.
- R4: With control = 0x06 (run, system-clock select at bit 1, external select at bit 0 clear), the count rises by one every clock cycle, starting at the edge after the control write.
- R5: With control = 0x04, the count rises by one every 12 cycles. The first step happens 12 edges after the edge that wrote the control register.
- R6: With control bit 0 set, the count rises by one for every 8 rising edges of `ext_osc`, and control bit 1 has no effect. With no edges on `ext_osc`, the count holds.
- R7: A tick at count 0xFFFF loads the reload value and sets the flag (control bit 7). For example, a preset of 0xFFFF with a reload of 0xFFF6 gives an overflow on the first tick and then one every 10 ticks.
- R8: The flag stays at 1 until a control write with bit 7 = 0 clears it. If an overflow falls on the same edge as a clearing write, the flag ends up set.
- R9: Control bits 6:3 always read as 0, whatever value is written to them.
- R10: `conv_start` is high for exactly the cycle after each overflow edge, with one pulse per overflow.
- R11: `irq` is high exactly when the flag is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_osc | input | 1 | Asynchronous external oscillator |
| wdata | input | 8 | Write data byte |
| wr_cnt_sel | input | 2 | Count byte write strobes (bit0 low byte, bit1 high byte) |
| wr_rld_sel | input | 2 | Reload byte write strobes (bit0 low byte, bit1 high byte) |
| wr_ctrl | input | 1 | Control register write strobe |
| irq_en | input | 1 | Interrupt enable |
| count_q | output | 16 | Current count |
| reload_q | output | 16 | Reload value |
| ctrl_q | output | 8 | Control read value {flag, 0000, run, sys select, ext select} |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle overflow strobe for a converter |

## Verification
Register writes and system-clock ticks change `count_q` and the flag one edge after they are presented. `conv_start` is high during the cycle that follows the overflow edge, and `irq` follows the flag within the same cycle. The divide-by-12 path makes its first step 12 edges after the control write. The external path passes through two synchronizer stages and an edge detector, so it takes about three edges to respond. The bench drives inputs and samples outputs on falling edges, and counts edges from each write to decide when to look. For the external source, it waits a margin of several cycles after the last oscillator edge before it reads the count.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

  // control register bit positions
  localparam int unsigned CB_EXT  = 0;
  localparam int unsigned CB_SYS  = 1;
  localparam int unsigned CB_RUN  = 2;
  localparam int unsigned CB_FLAG = 7;

  // modulo step of a prescaler counter
  function automatic logic [7:0] mod_step(input logic [7:0] cur, input int unsigned limit);
    if (cur == 8'(limit - 1)) return 8'd0;
    return cur + 8'd1;
  endfunction

  // pack control read value; unused bits read zero
  function automatic logic [7:0] ctrl_pack(input logic flag, input logic run,
                                           input logic sys_sel, input logic ext_sel);
    logic [7:0] v;
    v = 8'h00;
    v[CB_FLAG] = flag;
    v[CB_RUN]  = run;
    v[CB_SYS]  = sys_sel;
    v[CB_EXT]  = ext_sel;
    return v;
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic sys_sel,
  input  logic ext_osc,
  output logic tick
);
  import timer16_pkg::*;

  localparam int unsigned SYS_W = $clog2(SYS_DIV);
  localparam int unsigned EXT_W = $clog2(EXT_DIV);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   ext_rise;
  logic [EXT_W-1:0]       ext_cnt;
  logic [SYS_W-1:0]       pre_cnt;
  logic                   ext_active, div_active;
  logic                   ext_tick, div_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_osc};
      ext_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise   = sync_q[SYNC_STAGES-1] & ~ext_prev;
  assign ext_active = run & ext_sel;
  assign div_active = run & ~ext_sel & ~sys_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ext_cnt <= '0;
    else if (!ext_active) ext_cnt <= '0;
    else if (ext_rise)    ext_cnt <= EXT_W'(mod_step(8'(ext_cnt), EXT_DIV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre_cnt <= '0;
    else if (!div_active) pre_cnt <= '0;
    else                  pre_cnt <= SYS_W'(mod_step(8'(pre_cnt), SYS_DIV));
  end

  assign ext_tick = ext_active & ext_rise & (ext_cnt == EXT_W'(EXT_DIV - 1));
  assign div_tick = div_active & (pre_cnt == SYS_W'(SYS_DIV - 1));

  always_comb begin
    if (ext_sel)      tick = ext_tick;
    else if (sys_sel) tick = run;
    else              tick = div_tick;
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [7:0]           wdata,
  input  logic [CNT_W/8-1:0]   wr_cnt_sel,
  input  logic [CNT_W/8-1:0]   wr_rld_sel,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     reload,
  output logic                 wrap_evt
);
  localparam int unsigned NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_wr_val, rld_next;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign cnt_wr_val[b*8 +: 8] = wr_cnt_sel[b] ? wdata : count[b*8 +: 8];
      assign rld_next[b*8 +: 8]   = wr_rld_sel[b] ? wdata : reload[b*8 +: 8];
    end
  endgenerate

  assign wrap_evt = tick & (&count) & ~(|wr_cnt_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      reload <= rld_next;
      if (|wr_cnt_sel)   count <= cnt_wr_val;
      else if (wrap_evt) count <= reload;
      else if (tick)     count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  input  logic       wrap_evt,
  output logic       run,
  output logic       sys_sel,
  output logic       ext_sel,
  output logic       flag,
  output logic       conv_start,
  output logic [7:0] ctrl_rd
);
  import timer16_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; sys_sel <= 1'b0; ext_sel <= 1'b0;
      flag <= 1'b0; conv_start <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run     <= wdata[CB_RUN];
        sys_sel <= wdata[CB_SYS];
        ext_sel <= wdata[CB_EXT];
      end
      if (wrap_evt)     flag <= 1'b1;
      else if (wr_ctrl) flag <= wdata[CB_FLAG];
      conv_start <= wrap_evt;
    end
  end

  assign ctrl_rd = ctrl_pack(flag, run, sys_sel, ext_sel);

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_osc,
  input  logic [7:0]         wdata,
  input  logic [CNT_W/8-1:0] wr_cnt_sel,
  input  logic [CNT_W/8-1:0] wr_rld_sel,
  input  logic               wr_ctrl,
  input  logic               irq_en,
  output logic [CNT_W-1:0]   count_q,
  output logic [CNT_W-1:0]   reload_q,
  output logic [7:0]         ctrl_q,
  output logic               irq,
  output logic               conv_start
);
  logic run_en, sys_sel, ext_sel, flag;
  logic tick_en, wrap_evt;

  tmr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .wrap_evt(wrap_evt), .run(run_en), .sys_sel(sys_sel), .ext_sel(ext_sel),
    .flag(flag), .conv_start(conv_start), .ctrl_rd(ctrl_q)
  );

  tmr_tick_gen #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_en), .ext_sel(ext_sel),
    .sys_sel(sys_sel), .ext_osc(ext_osc), .tick(tick_en)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wdata(wdata),
    .wr_cnt_sel(wr_cnt_sel), .wr_rld_sel(wr_rld_sel),
    .count(count_q), .reload(reload_q), .wrap_evt(wrap_evt)
  );

  assign irq = flag & irq_en;

endmodule

// File: rtl/timer16_checker.sv
module timer16_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W/8-1:0] wr_cnt_sel,
  input logic               wr_ctrl,
  input logic               irq_en,
  input logic [CNT_W-1:0]   count_q,
  input logic [CNT_W-1:0]   reload_q,
  input logic [7:0]         ctrl_q,
  input logic               irq,
  input logic               conv_start,
  input logic               tick_en,
  input logic               wrap_evt
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !(|wr_cnt_sel)) |=> $stable(count_q)); // R3
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> ctrl_q[2]); // R3
  AST_WRAP_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count_q == $past(reload_q) && ctrl_q[7])); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !wr_ctrl) |=> ctrl_q[7]); // R8
  AST_CONV_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(wrap_evt) && ctrl_q[7])); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R11
endmodule

bind reload_timer16 timer16_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cnt_sel(wr_cnt_sel), .wr_ctrl(wr_ctrl),
  .irq_en(irq_en), .count_q(count_q), .reload_q(reload_q), .ctrl_q(ctrl_q),
  .irq(irq), .conv_start(conv_start), .tick_en(tick_en), .wrap_evt(wrap_evt)
);

// File: tb/tb_reload_timer16.sv
module tb_reload_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_osc = 1'b0;
  logic [7:0]  wdata = '0;
  logic [1:0]  wr_cnt_sel = '0, wr_rld_sel = '0;
  logic        wr_ctrl = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] count_q, reload_q;
  logic [7:0]  ctrl_q;
  logic        irq, conv_start;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reload_timer16 dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr_ctrl_byte(input logic [7:0] v);
    wdata = v; wr_ctrl = 1'b1;
    @(negedge clk);
    wr_ctrl = 1'b0;
  endtask

  task automatic wr_count(input logic [15:0] v);
    wdata = v[7:0];  wr_cnt_sel = 2'b01; @(negedge clk);
    wdata = v[15:8]; wr_cnt_sel = 2'b10; @(negedge clk);
    wr_cnt_sel = 2'b00;
  endtask

  task automatic wr_reload(input logic [15:0] v);
    wdata = v[7:0];  wr_rld_sel = 2'b01; @(negedge clk);
    wdata = v[15:8]; wr_rld_sel = 2'b10; @(negedge clk);
    wr_rld_sel = 2'b00;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_osc = 1'b1; repeat (3) @(negedge clk);
      ext_osc = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check(count_q == 16'h0, "R1 count", count_q, 0);
    check(reload_q == 16'h0, "R1 reload", reload_q, 0);
    check(ctrl_q == 8'h0, "R1 ctrl", ctrl_q, 0);
    check(!irq && !conv_start, "R1 irq/conv", {irq, conv_start}, 0);
  endtask

  task automatic t_writes_and_stop();
    wr_count(16'h4321); wr_reload(16'hABCD);
    check(count_q == 16'h4321, "R2 count bytes", count_q, 16'h4321);
    check(reload_q == 16'hABCD, "R2 reload bytes", reload_q, 16'hABCD);
    wr_ctrl_byte(8'h02);
    repeat (20) @(negedge clk);
    check(count_q == 16'h4321, "R3 stopped hold", count_q, 16'h4321);
    wr_ctrl_byte(8'h78);
    check(ctrl_q == 8'h00, "R9 reserved bits zero", ctrl_q, 8'h00);
  endtask

  task automatic t_sysclk();
    wr_count(16'h1200);
    wr_ctrl_byte(8'h06);
    check(count_q == 16'h1200, "R4 no step on write edge", count_q, 16'h1200);
    repeat (5) @(negedge clk);
    check(count_q == 16'h1205, "R4 per-cycle step", count_q, 16'h1205);
    wdata = 8'h50; wr_cnt_sel = 2'b01; @(negedge clk); wr_cnt_sel = 2'b00;
    check(count_q == 16'h1250, "R2 write beats tick", count_q, 16'h1250);
    @(negedge clk);
    check(count_q == 16'h1251, "R2 count resumes", count_q, 16'h1251);
    wr_ctrl_byte(8'h00);
  endtask

  task automatic t_div12();
    wr_count(16'h0000);
    wr_ctrl_byte(8'h04);
    repeat (11) @(negedge clk);
    check(count_q == 16'h0000, "R5 before 12th edge", count_q, 0);
    @(negedge clk);
    check(count_q == 16'h0001, "R5 first step", count_q, 1);
    repeat (12) @(negedge clk);
    check(count_q == 16'h0002, "R5 second step", count_q, 2);
    wr_ctrl_byte(8'h00);
  endtask

  task automatic t_ext();
    wr_count(16'h0100);
    wr_ctrl_byte(8'h07);
    ext_pulses(16);
    check(count_q == 16'h0102, "R6 16 edges", count_q, 16'h0102);
    ext_pulses(7);
    check(count_q == 16'h0102, "R6 7 edges no step", count_q, 16'h0102);
    ext_pulses(1);
    check(count_q == 16'h0103, "R6 8th edge", count_q, 16'h0103);
    repeat (40) @(negedge clk);
    check(count_q == 16'h0103, "R6 sys select ignored", count_q, 16'h0103);
    wr_ctrl_byte(8'h00);
  endtask

  task automatic t_period();
    int pulses = 0;
    wr_reload(16'hFFF6); wr_count(16'hFFFF);
    wr_ctrl_byte(8'h06);
    @(negedge clk);
    check(count_q == 16'hFFF6, "R7 immediate reload", count_q, 16'hFFF6);
    check(ctrl_q[7], "R7 flag set", ctrl_q, 8'h86);
    check(conv_start, "R10 strobe after wrap", conv_start, 1);
    @(negedge clk);
    check(!conv_start, "R10 single cycle", conv_start, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (conv_start) pulses++;
    end
    check(pulses == 3, "R7 period of 10 ticks", pulses, 3);
    wr_ctrl_byte(8'h00);
    check(ctrl_q == 8'h00, "R8 software clear", ctrl_q, 0);
  endtask

  task automatic t_sticky_irq();
    irq_en = 1'b0;
    wr_reload(16'h1000); wr_count(16'hFFFF);
    wr_ctrl_byte(8'h06);
    @(negedge clk);
    check(ctrl_q[7] && !irq, "R11 masked", {ctrl_q[7], irq}, 2'b10);
    wr_ctrl_byte(8'h80);
    repeat (20) @(negedge clk);
    check(ctrl_q == 8'h80, "R8 flag sticky", ctrl_q, 8'h80);
    irq_en = 1'b1; #1;
    check(irq, "R11 irq raised", irq, 1);
    @(negedge clk);
    wr_ctrl_byte(8'h00);
    check(!irq && !ctrl_q[7], "R11 irq drops on clear", {ctrl_q[7], irq}, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_set_wins();
    wr_count(16'hFFFD);
    wr_ctrl_byte(8'h06);
    repeat (2) @(negedge clk);
    wr_ctrl_byte(8'h06);
    check(ctrl_q[7], "R8 overflow beats clear", ctrl_q, 8'h86);
    wr_ctrl_byte(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes_and_stop();
    t_sysclk();
    t_div12();
    t_ext();
    t_period();
    t_sticky_irq();
    t_set_wins();
    finish_run();
  end

  initial begin
    #1ms;
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end
endmodule